// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block derives the bit-clock timing and the frame-sync level of a synchronous audio serial port from a faster system clock. A divider turns the system clock into a one-cycle bit-clock enable strobe. A frame counter advancing on those strobes shapes the sync output and marks the first bit clock of every frame with a strobe, so the transmit and receive shifters can align to it.

Software writes the divider, the frame length and the sync length. Each is given as the count minus one. The frame shape can also come from a built-in format: the two-channel stereo format uses a 32-clock frame with a half-frame active-low sync. The two PCM formats use a 256-clock frame with a one-clock active-high sync. The bit-clock enable and the frame enable are two separate controls, and one close strobe returns the whole block to its reset state.

Top module: `bfs_gen`

## Requirements
- R1: After reset, `bclk_en`, `fsync` and `frame_start` are all 0.
- R2: With the bit-clock enable set and divider field D, `bclk_en` is a one-cycle pulse every D+1 system cycles. With the bit-clock enable clear, no pulses come out.
- R3: A divider field of 0 makes `bclk_en` high on every system cycle while the bit-clock enable is set.
- R4: In custom format (`cfg_fmt` = 0), each frame is P+1 bit clocks long, where P is the period field. The sync is active for the first W+1 bit clocks, where W is the width field. Active is high when `cfg_act_low` = 0 and low when it is 1. `fsync` and `frame_start` update one system cycle after the `bclk_en` pulse that advances them.
- R5: `frame_start` is high for exactly one system cycle, on the first bit clock of each frame.
- R6: `cfg_fmt` = 1 selects the stereo format: a 32-bit-clock frame with an active-low sync lasting 16 bit clocks. The period, width and polarity inputs are ignored in this format.
- R7: `cfg_fmt` = 2 and `cfg_fmt` = 3 both select a 256-bit-clock frame with an active-high sync lasting one bit clock.
- R8: A configuration load that arrives while the bit-clock enable is set has no effect.
- R9: While the frame enable is clear, `fsync` sits at its inactive level and `frame_start` stays 0, even though `bclk_en` keeps running.
- R10: A `close` strobe clears both enables and zeroes the divider, period, width and polarity. If the generator is then re-enabled without a new load, it runs at divide-by-1 with a one-clock frame.
- R11: Setting the frame enable always starts a new frame at position 0, whatever position the frame counter had reached before it was cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| close | input | 1 | Strobe: clear enables and configuration |
| en_wr | input | 1 | Strobe: write both enable bits |
| en_bclk | input | 1 | Bit-clock generator enable value |
| en_frame | input | 1 | Frame generator enable value |
| cfg_load | input | 1 | Strobe: load configuration |
| cfg_fmt | input | 2 | 0 custom, 1 stereo, 2 PCM, 3 companded PCM |
| cfg_div | input | DIV_W | Divider minus one |
| cfg_period | input | CNT_W | Frame length minus one (custom format) |
| cfg_width | input | CNT_W | Sync length minus one (custom format) |
| cfg_act_low | input | 1 | Sync active low (custom format) |
| bclk_en | output | 1 | One-cycle bit-clock strobe |
| fsync | output | 1 | Frame sync, with polarity applied |
| frame_start | output | 1 | Strobe on the first bit clock of a frame |

## Verification
The bench attacks four weak spots.

- Off-by-one errors in the minus-one fields: a wrong divider shows up as a changed pulse spacing, and a wrong frame wrap or sync length shifts the frame pattern against the scoreboard.
- A load issued mid-stream: a design that accepted it would change the pattern partway through the expected sequence.
- Stopping the frame enable mid-frame and starting it again: a design that resumed instead of restarting would emit a sync at a position other than 0.
- A close followed by a bare re-enable: a design that kept any old field would show a divider gap or a frame shape other than the all-zero one.

// File: rtl/bfs_pkg.sv
// Shared definitions for the bit-clock / frame-sync generator.
// Assumes the frame counter width is at least 8 bits so the PCM preset fits.
package bfs_pkg;

    typedef enum logic [1:0] {
        FMT_CUSTOM   = 2'd0,
        FMT_STEREO   = 2'd1,
        FMT_PCM      = 2'd2,
        FMT_PCM_COMP = 2'd3
    } fmt_e;

    localparam int STEREO_PERIOD = 31;
    localparam int STEREO_WIDTH  = 15;
    localparam int PCM_PERIOD    = 255;
    localparam int PCM_WIDTH     = 0;

endpackage

// File: rtl/bfs_cfg.sv
// Holds the enables and the framing configuration.
// Assumes that loads are only legal while the bit-clock generator is off;
// loads at other times are dropped. Close overrides every other write.
module bfs_cfg
    import bfs_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close,
    input  logic             en_wr,
    input  logic             en_bclk,
    input  logic             en_frame,
    input  logic             cfg_load,
    input  logic [1:0]       cfg_fmt,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             cfg_act_low,
    output logic             bclk_on,
    output logic             frm_on,
    output logic [DIV_W-1:0] div_q,
    output logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] wid_q,
    output logic             act_low_q
);

    logic [CNT_W-1:0] per_sel;
    logic [CNT_W-1:0] wid_sel;
    logic             low_sel;

    // Pick the framing from either a preset or the custom fields.
    always_comb begin
        case (fmt_e'(cfg_fmt))
            FMT_STEREO: begin
                per_sel = CNT_W'(STEREO_PERIOD);
                wid_sel = CNT_W'(STEREO_WIDTH);
                low_sel = 1'b1;
            end
            FMT_PCM, FMT_PCM_COMP: begin
                per_sel = CNT_W'(PCM_PERIOD);
                wid_sel = CNT_W'(PCM_WIDTH);
                low_sel = 1'b0;
            end
            default: begin
                per_sel = cfg_period;
                wid_sel = cfg_width;
                low_sel = cfg_act_low;
            end
        endcase
    end

    // Register the enables and the configuration; close clears all of it.
    always_ff @(posedge clk) begin
        if (!rst_n || close) begin
            bclk_on   <= 1'b0;
            frm_on    <= 1'b0;
            div_q     <= '0;
            per_q     <= '0;
            wid_q     <= '0;
            act_low_q <= 1'b0;
        end else begin
            if (en_wr) begin
                bclk_on <= en_bclk;
                frm_on  <= en_frame;
            end
            if (cfg_load && !bclk_on) begin
                div_q     <= cfg_div;
                per_q     <= per_sel;
                wid_q     <= wid_sel;
                act_low_q <= low_sel;
            end
        end
    end

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_on && $past(bclk_on)) |-> ($stable(div_q) && $stable(per_q)
                                         && $stable(wid_q) && $stable(act_low_q)));

    a_r10_close_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(close) |-> (!bclk_on && !frm_on && div_q == '0 && per_q == '0));

endmodule

// File: rtl/bfs_divider.sv
// Bit-clock divider: emits a one-cycle tick every div+1 input cycles.
// Assumes div is held stable while run is high.
module bfs_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Count input cycles and raise the tick when the count wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end

    a_r2_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !tick);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div));

    a_r3_div0_every: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $past(div) == '0) |-> tick);

endmodule

// File: rtl/bfs_framer.sv
// Frame position counter: advances once per bit-clock tick, shapes the
// raw (active-high) sync and the frame-start strobe. Assumes per/wid are
// minus-one values; the first tick after run rises is position 0.
module bfs_framer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] wid,
    output logic             sync_act,
    output logic             start
);

    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] pos_nxt;
    logic             fresh;

    // Next position: restart after enable, wrap at the end of the frame.
    always_comb begin
        if (fresh || pos >= per) pos_nxt = '0;
        else                     pos_nxt = pos + CNT_W'(1);
    end

    // Step the position on each tick and register the frame outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos      <= '0;
            fresh    <= 1'b1;
            sync_act <= 1'b0;
            start    <= 1'b0;
        end else if (tick) begin
            pos      <= pos_nxt;
            fresh    <= 1'b0;
            sync_act <= (pos_nxt <= wid);
            start    <= (pos_nxt == '0);
        end else begin
            start    <= 1'b0;
        end
    end

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (!sync_act && !start));

    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        (start && per != '0) |=> !start);

    a_r4_sync_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> sync_act);

endmodule

// File: rtl/bfs_gen.sv
// Top of the bit-clock / frame-sync generator. Joins the configuration
// holder, the divider and the frame counter and applies sync polarity.
// Assumes CNT_W >= 8 so the PCM preset frame fits.
module bfs_gen #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close,
    input  logic             en_wr,
    input  logic             en_bclk,
    input  logic             en_frame,
    input  logic             cfg_load,
    input  logic [1:0]       cfg_fmt,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             cfg_act_low,
    output logic             bclk_en,
    output logic             fsync,
    output logic             frame_start
);

    logic             bclk_on;
    logic             frm_on;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] wid_q;
    logic             act_low_q;
    logic             sync_act;

    bfs_cfg #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .close(close),
        .en_wr(en_wr), .en_bclk(en_bclk), .en_frame(en_frame),
        .cfg_load(cfg_load), .cfg_fmt(cfg_fmt), .cfg_div(cfg_div),
        .cfg_period(cfg_period), .cfg_width(cfg_width), .cfg_act_low(cfg_act_low),
        .bclk_on(bclk_on), .frm_on(frm_on), .div_q(div_q),
        .per_q(per_q), .wid_q(wid_q), .act_low_q(act_low_q)
    );

    bfs_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(bclk_on), .div(div_q), .tick(bclk_en)
    );

    bfs_framer #(.CNT_W(CNT_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .run(frm_on), .tick(bclk_en),
        .per(per_q), .wid(wid_q), .sync_act(sync_act), .start(frame_start)
    );

    // Apply the selected polarity to the raw sync level.
    assign fsync = sync_act ^ act_low_q;

endmodule

// File: tb/sim_bfs_gen.sv
module sim_bfs_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       close = 1'b0;
    logic       en_wr = 1'b0;
    logic       en_bclk = 1'b0;
    logic       en_frame = 1'b0;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_fmt = 2'd0;
    logic [7:0] cfg_div = 8'd0;
    logic [7:0] cfg_period = 8'd0;
    logic [7:0] cfg_width = 8'd0;
    logic       cfg_act_low = 1'b0;
    logic       bclk_en, fsync, frame_start;

    always #5 clk = ~clk;

    bfs_gen u0 (
        .clk(clk), .rst_n(rst_n), .close(close), .en_wr(en_wr),
        .en_bclk(en_bclk), .en_frame(en_frame), .cfg_load(cfg_load),
        .cfg_fmt(cfg_fmt), .cfg_div(cfg_div), .cfg_period(cfg_period),
        .cfg_width(cfg_width), .cfg_act_low(cfg_act_low),
        .bclk_en(bclk_en), .fsync(fsync), .frame_start(frame_start)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    // scoreboard queues
    bit    q_fs[$];
    bit    q_st[$];
    string q_tag[$];

    // model state
    int m_pos = 0;
    bit m_fresh = 1;
    int m_per = 0, m_wid = 0;
    bit m_low = 0;

    // gap monitor
    bit gap_on = 0;
    bit last_v = 0;
    int last_cyc = 0;
    int exp_gap = 1;
    int cyc = 0;
    bit prev_b = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(int n, string tag);
        for (int i = 0; i < n; i++) begin
            if (m_fresh) begin m_pos = 0; m_fresh = 0; end
            else if (m_pos >= m_per) m_pos = 0;
            else m_pos = m_pos + 1;
            q_fs.push_back((m_pos <= m_wid) ^ m_low);
            q_st.push_back(m_pos == 0);
            q_tag.push_back(tag);
        end
    endtask

    task automatic model(int per, int wid, bit low);
        m_per = per; m_wid = wid; m_low = low; m_fresh = 1;
    endtask

    task automatic wait_empty();
        while (q_fs.size() > 0) @(negedge clk);
    endtask

    task automatic set_en(bit b, bit f);
        @(negedge clk);
        en_wr = 1; en_bclk = b; en_frame = f;
        @(negedge clk);
        en_wr = 0;
        #1;
    endtask

    task automatic load(logic [1:0] fmt, int dv, int per, int wid, bit low);
        @(negedge clk);
        cfg_load = 1; cfg_fmt = fmt; cfg_div = 8'(dv);
        cfg_period = 8'(per); cfg_width = 8'(wid); cfg_act_low = low;
        @(negedge clk);
        cfg_load = 0;
        #1;
    endtask

    task automatic do_close();
        @(negedge clk);
        close = 1;
        @(negedge clk);
        close = 0;
        #1;
    endtask

    task automatic start_gap(int g);
        exp_gap = g; last_v = 0; gap_on = 1;
    endtask

    // monitor: pops expected frame items and checks bit-clock spacing
    always @(negedge clk) begin
        cyc++;
        if (prev_b && q_fs.size() > 0) begin
            bit e_fs, e_st;
            string t;
            e_fs = q_fs.pop_front();
            e_st = q_st.pop_front();
            t = q_tag.pop_front();
            chk(fsync == e_fs, t, int'(fsync), int'(e_fs));
            chk(frame_start == e_st, "R5", int'(frame_start), int'(e_st));
        end
        if (gap_on && bclk_en) begin
            if (last_v) chk((cyc - last_cyc) == exp_gap, "R2", cyc - last_cyc, exp_gap);
            last_cyc = cyc;
            last_v = 1;
        end
        prev_b = bclk_en;
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bclk_en == 0, "R1", int'(bclk_en), 0);
        chk(fsync == 0, "R1", int'(fsync), 0);
        chk(frame_start == 0, "R1", int'(frame_start), 0);
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R4/R2: custom frame, divide by 3, 4-clock frame, 2-clock active-high sync
        load(2'd0, 2, 3, 1, 0);
        start_gap(3);
        set_en(1, 1);
        model(3, 1, 0);
        push(12, "R4");
        while (q_fs.size() > 6) @(negedge clk);
        // R8: load while running must be dropped
        load(2'd0, 0, 7, 2, 1);
        push(12, "R8");
        wait_empty();

        // R2: stopping the clock generator
        gap_on = 0;
        set_en(0, 0);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            chk(bclk_en == 0, "R2", int'(bclk_en), 0);
            chk(fsync == 0, "R9", int'(fsync), 0);
            @(negedge clk);
        end

        // R6 with R3 and R9: stereo preset, divide by 1, frame off first
        load(2'd1, 0, 5, 5, 0);
        chk(fsync == 1, "R6", int'(fsync), 1);
        start_gap(1);
        set_en(1, 0);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            chk(fsync == 1, "R9", int'(fsync), 1);
            chk(frame_start == 0, "R9", int'(frame_start), 0);
            chk(bclk_en == 1, "R3", int'(bclk_en), 1);
            @(negedge clk);
        end
        set_en(1, 1);
        model(31, 15, 1);
        push(69, "R6");
        wait_empty();

        // R11: stop frames mid-frame, restart at position 0
        set_en(1, 0);
        repeat (3) @(negedge clk);
        chk(fsync == 1, "R9", int'(fsync), 1);
        chk(frame_start == 0, "R9", int'(frame_start), 0);
        set_en(1, 1);
        model(31, 15, 1);
        push(33, "R11");
        wait_empty();

        // R7: PCM preset, divide by 2
        gap_on = 0;
        set_en(0, 0);
        repeat (3) @(negedge clk);
        load(2'd2, 1, 9, 9, 1);
        start_gap(2);
        set_en(1, 1);
        model(255, 0, 0);
        push(300, "R7");
        wait_empty();

        // R7: companded PCM preset, divide by 1
        gap_on = 0;
        set_en(0, 0);
        repeat (3) @(negedge clk);
        load(2'd3, 0, 3, 3, 1);
        start_gap(1);
        set_en(1, 1);
        model(255, 0, 0);
        push(260, "R7");
        wait_empty();

        // R10: close while running, then bare re-enable
        gap_on = 0;
        do_close();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            chk(bclk_en == 0, "R10", int'(bclk_en), 0);
            chk(fsync == 0, "R10", int'(fsync), 0);
            chk(frame_start == 0, "R10", int'(frame_start), 0);
            @(negedge clk);
        end
        start_gap(1);
        set_en(1, 1);
        model(0, 0, 0);
        push(10, "R10");
        wait_empty();
        repeat (3) @(negedge clk);

        summary();
    end

endmodule